// File: doc/BRIEF.md
# Partitionable CAN Identifier Acceptance Filter

This block decides, one frame at a time, whether a received CAN identifier should be kept. It holds eight code bytes and eight mask bytes, arranged as two banks of four. A 2-bit partition mode organises that storage in one of four ways:
- two filters of 32 bits each;
- four filters of 16 bits each;
- eight filters of 8 bits each;
- closed, where every frame is rejected.

The four identifier bytes come in exactly as the receive buffer stores them. When the frame-valid strobe is high, every active filter compares its bytes in parallel. One clock later the block gives an accept pulse and the number of the filter that hit.

Software programs the codes, masks and mode through a simple write port, and only while the init-mode input is high. A mask bit of 1 makes that identifier bit don't-care. The block is meant to sit between the bit-level CAN receiver and the receive FIFO, and to gate loading of the foreground buffer.

Top module: `can_id_filter`

## Requirements
- R1: Mode 2'b00 forms two 32-bit filters. Filter 0 compares identifier bytes 0..3 with code/mask slots 0..3, and filter 1 compares them with slots 4..7. Identifier byte n is `id_bytes[31-8n -: 8]`, so byte 0 is bits 31:24.
- R2: Mode 2'b01 forms four 16-bit filters. Filter k compares identifier bytes 0 and 1 with slots 2k and 2k+1.
- R3: Mode 2'b10 forms eight 8-bit filters. Filter k compares identifier byte 0 with slot k.
- R4: Mode 2'b11 is closed: `accept` never rises.
- R5: A filter byte matches when `((id ^ code) & ~mask) == 0`. A mask bit of 1 makes that bit don't-care. A filter hits only when all of its bytes match.
- R6: When several filters hit, `hit_idx` reports the lowest-numbered one.
- R7: `accept` is high for exactly the cycle after a cycle with `frame_valid` high and at least one hit. When `accept` is low, `hit_idx` is 0.
- R8: Register writes take effect only while `init_mode` is 1. Outside init mode, writes change no code, mask or mode.
- R9: After reset, the mode is closed (2'b11), all code and mask bytes are 0, and `accept` and `hit_idx` are 0.
- R10: Write address map:
  - addresses 0..7 write code slot n;
  - addresses 8..15 write mask slot n-8;
  - address 16 writes the mode from `wr_data[1:0]`;
  - addresses 17..31 are ignored.
- R11: For an 11-bit standard identifier, ID[10:3] sits in byte 0 and ID[2:0] sits in byte 1 bits 7:5. With byte-1 mask bits 4:0 set, a filter coded for one standard identifier accepts that identifier and rejects its neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_mode | input | 1 | Configuration window; writes are honoured only while this is 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| frame_valid | input | 1 | Identifier bytes are valid this cycle |
| id_bytes | input | 32 | Received identifier bytes, byte 0 in bits 31:24 |
| accept | output | 1 | One-cycle pulse: frame accepted |
| hit_idx | output | 3 | Lowest hitting filter number, 0 when not accepting |

## Verification
The assertions check several behaviours on every cycle:
- an accept pulse is always preceded by a valid frame;
- a closed filter never accepts;
- the reported index lies inside the filter count of the mode in force;
- no lower-numbered filter was also hitting;
- the index is zero whenever accept is low;
- code, mask and mode storage never moves outside init mode.

Whether the comparison itself is right cannot be shown by these properties. That covers the byte-to-slot pairing in each partition, the mask-as-don't-care rule, the address decode and the standard-identifier layout. These are shown only by the bench's scenarios, which compare each accept and index against a separately written model of the codes and masks the bench itself programmed.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  typedef enum logic [1:0] {
    FM_WIDE = 2'b00,
    FM_HALF = 2'b01,
    FM_BYTE = 2'b10,
    FM_SHUT = 2'b11
  } filt_mode_e;

  // One byte comparison: every bit not masked must equal the code bit.
  function automatic logic byte_match(input logic [7:0] idb,
                                      input logic [7:0] code,
                                      input logic [7:0] mask);
    return ((idb ^ code) & ~mask) == 8'h00;
  endfunction

  // Which identifier byte a storage slot is compared with, per partition.
  function automatic int unsigned id_byte_for_slot(input filt_mode_e mode,
                                                   input int unsigned slot,
                                                   input int unsigned id_bytes);
    case (mode)
      FM_WIDE: return slot % id_bytes;
      FM_HALF: return slot % 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
  import can_filt_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int BYTE_W = 8,
  parameter int AW     = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init_mode,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic [SLOTS*BYTE_W-1:0] code_q,
  output logic [SLOTS*BYTE_W-1:0] mask_q,
  output filt_mode_e              mode_q
);

  localparam int MASK_BASE = SLOTS;
  localparam int MODE_ADDR = 2 * SLOTS;

  logic wr_ok;
  assign wr_ok = wr_en & init_mode;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[s*BYTE_W +: BYTE_W] <= '0;
        mask_q[s*BYTE_W +: BYTE_W] <= '0;
      end else if (wr_ok) begin
        if (wr_addr == AW'(s))
          code_q[s*BYTE_W +: BYTE_W] <= wr_data;
        if (wr_addr == AW'(MASK_BASE + s))
          mask_q[s*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= FM_SHUT;
    else if (wr_ok && wr_addr == AW'(MODE_ADDR))
      mode_q <= filt_mode_e'(wr_data[1:0]);
  end

endmodule

// File: rtl/can_filt_cmp.sv
module can_filt_cmp
  import can_filt_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int BYTE_W   = 8,
  parameter int ID_BYTES = 4
) (
  input  logic [ID_BYTES*BYTE_W-1:0] id_bytes,
  input  logic [SLOTS*BYTE_W-1:0]    code_q,
  input  logic [SLOTS*BYTE_W-1:0]    mask_q,
  input  filt_mode_e                 mode_q,
  output logic [SLOTS-1:0]           byte_hit
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    logic [BYTE_W-1:0] sel_byte;
    int unsigned       src;
    always_comb begin
      src      = id_byte_for_slot(mode_q, s, ID_BYTES);
      sel_byte = id_bytes[(ID_BYTES-1-src)*BYTE_W +: BYTE_W];
    end
    assign byte_hit[s] = byte_match(sel_byte,
                                    code_q[s*BYTE_W +: BYTE_W],
                                    mask_q[s*BYTE_W +: BYTE_W]);
  end

endmodule

// File: rtl/can_filt_merge.sv
module can_filt_merge
  import can_filt_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int ID_BYTES = 4,
  parameter int IDXW     = 3
) (
  input  filt_mode_e       mode_q,
  input  logic [SLOTS-1:0] byte_hit,
  output logic [SLOTS-1:0] filt_hit,
  output logic             any_hit,
  output logic [IDXW-1:0]  first_idx
);

  localparam int N_WIDE = SLOTS / ID_BYTES;
  localparam int N_HALF = SLOTS / 2;

  for (genvar k = 0; k < SLOTS; k++) begin : g_filt
    logic wide_h, half_h;
    if (k < N_WIDE) begin : g_w
      assign wide_h = &byte_hit[k*ID_BYTES +: ID_BYTES];
    end else begin : g_wn
      assign wide_h = 1'b0;
    end
    if (k < N_HALF) begin : g_h
      assign half_h = &byte_hit[k*2 +: 2];
    end else begin : g_hn
      assign half_h = 1'b0;
    end
    always_comb begin
      case (mode_q)
        FM_WIDE: filt_hit[k] = wide_h;
        FM_HALF: filt_hit[k] = half_h;
        FM_BYTE: filt_hit[k] = byte_hit[k];
        default: filt_hit[k] = 1'b0;
      endcase
    end
  end

  // Lowest-numbered hit wins.
  always_comb begin
    first_idx = '0;
    for (int k = SLOTS - 1; k >= 0; k--)
      if (filt_hit[k]) first_idx = IDXW'(k);
  end

  assign any_hit = |filt_hit;

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_filt_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int BYTE_W   = 8,
  parameter int ID_BYTES = 4,
  parameter int AW       = 5,
  parameter int IDXW     = $clog2(SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       init_mode,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic                       frame_valid,
  input  logic [ID_BYTES*BYTE_W-1:0] id_bytes,
  output logic                       accept,
  output logic [IDXW-1:0]            hit_idx
);

  logic [SLOTS*BYTE_W-1:0] code_q, mask_q;
  filt_mode_e              mode_q;
  logic [SLOTS-1:0]        byte_hit, filt_hit;
  logic                    any_hit;
  logic [IDXW-1:0]         first_idx;
  logic                    take_frame;

  can_filt_regs #(.SLOTS(SLOTS), .BYTE_W(BYTE_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .code_q(code_q), .mask_q(mask_q), .mode_q(mode_q)
  );

  can_filt_cmp #(.SLOTS(SLOTS), .BYTE_W(BYTE_W), .ID_BYTES(ID_BYTES)) u_cmp (
    .id_bytes(id_bytes), .code_q(code_q), .mask_q(mask_q),
    .mode_q(mode_q), .byte_hit(byte_hit)
  );

  can_filt_merge #(.SLOTS(SLOTS), .ID_BYTES(ID_BYTES), .IDXW(IDXW)) u_merge (
    .mode_q(mode_q), .byte_hit(byte_hit), .filt_hit(filt_hit),
    .any_hit(any_hit), .first_idx(first_idx)
  );

  assign take_frame = frame_valid & any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept  <= 1'b0;
      hit_idx <= '0;
    end else begin
      accept  <= take_frame;
      hit_idx <= take_frame ? first_idx : '0;
    end
  end

endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk
  import can_filt_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int BYTE_W = 8,
  parameter int IDXW   = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    init_mode,
  input logic                    frame_valid,
  input logic                    accept,
  input logic [IDXW-1:0]         hit_idx,
  input filt_mode_e              mode_q,
  input logic [SLOTS-1:0]        filt_hit,
  input logic [SLOTS*BYTE_W-1:0] code_q,
  input logic [SLOTS*BYTE_W-1:0] mask_q
);

  function automatic int unsigned filt_count(input filt_mode_e m);
    case (m)
      FM_WIDE: return 2;
      FM_HALF: return 4;
      FM_BYTE: return 8;
      default: return 0;
    endcase
  endfunction

  logic [SLOTS-1:0] below_idx;
  assign below_idx = (SLOTS'(1) << hit_idx) - SLOTS'(1);

  // R7
  accept_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(frame_valid));

  // R4
  closed_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FM_SHUT) |=> !accept);

  // R6
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (32'(hit_idx) < filt_count($past(mode_q))));

  // R6
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (($past(filt_hit) & below_idx) == '0));

  // R7
  idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> (hit_idx == '0));

  // R8
  locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_mode |=> ($stable(mode_q) && $stable(code_q) && $stable(mask_q)));

endmodule

bind can_id_filter can_filt_chk #(.SLOTS(SLOTS), .BYTE_W(BYTE_W), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .frame_valid(frame_valid),
  .accept(accept), .hit_idx(hit_idx), .mode_q(mode_q), .filt_hit(filt_hit),
  .code_q(code_q), .mask_q(mask_q)
);

// File: tb/sim_can_id_filter.sv
`timescale 1ns/1ps
module sim_can_id_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        frame_valid = 1'b0;
  logic [31:0] id_bytes = '0;
  logic        accept;
  logic [2:0]  hit_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench-side shadow of what has been programmed.
  logic [7:0] sh_code [8];
  logic [7:0] sh_mask [8];
  logic [1:0] sh_mode;

  always #2 clk = ~clk;

  can_id_filter u0 (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .frame_valid(frame_valid),
    .id_bytes(id_bytes), .accept(accept), .hit_idx(hit_idx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model: filter count and bytes per filter, then first full match.
  function automatic void model(input logic [31:0] id, output logic hit, output logic [2:0] idx);
    int nf, w;
    hit = 1'b0;
    idx = 3'd0;
    case (sh_mode)
      2'b00: begin nf = 2; w = 4; end
      2'b01: begin nf = 4; w = 2; end
      2'b10: begin nf = 8; w = 1; end
      default: begin nf = 0; w = 1; end
    endcase
    for (int k = nf - 1; k >= 0; k--) begin
      bit ok = 1'b1;
      for (int b = 0; b < w; b++) begin
        logic [7:0] ib = id[31 - 8*b -: 8];
        if (((ib ^ sh_code[k*w+b]) & ~sh_mask[k*w+b]) != 8'h00) ok = 1'b0;
      end
      if (ok) begin hit = 1'b1; idx = 3'(k); end
    end
  endfunction

  task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (init_mode) begin
      if (a < 5'd8) sh_code[a] = d;
      else if (a < 5'd16) sh_mask[a-8] = d;
      else if (a == 5'd16) sh_mode = d[1:0];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input string req, input logic [31:0] id);
    logic eh; logic [2:0] ei;
    model(id, eh, ei);
    @(negedge clk);
    frame_valid = 1'b1; id_bytes = id;
    @(negedge clk);
    frame_valid = 1'b0;
    check(req, {31'd0, accept}, {31'd0, eh});
    check(req, {29'd0, hit_idx}, {29'd0, eh ? ei : 3'd0});
  endtask

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin sh_code[i] = 8'h00; sh_mask[i] = 8'h00; end
    sh_mode = 2'b11;
    repeat (3) @(negedge clk);
    // R9: reset outputs
    check("R9 accept after reset", {31'd0, accept}, 32'd0);
    check("R9 hit_idx after reset", {29'd0, hit_idx}, 32'd0);
    rst_n = 1'b1;
    // R9/R4: reset mode is closed; all-zero id matches zero codes yet is rejected
    send("R9 R4 closed at reset", 32'h0000_0000);

    // R11 / R1: standard ID 0x55 -> byte0 0x0A, byte1 0xA0
    init_mode = 1'b1;
    reg_write(5'd0, 8'h0A); reg_write(5'd1, 8'hA0);
    reg_write(5'd8, 8'h00); reg_write(5'd9, 8'h1F);
    reg_write(5'd10, 8'hFF); reg_write(5'd11, 8'hFF);
    for (int i = 4; i < 8; i++) begin reg_write(5'(i), 8'hFF); reg_write(5'(8+i), 8'h00); end
    reg_write(5'd16, 8'h00);
    init_mode = 1'b0;
    send("R11 std id 0x55 accepted", 32'h0AA0_1234);
    send("R11 std id 0x56 rejected", 32'h0AC0_0000);
    send("R11 std id 0x54 rejected", 32'h0A80_0000);
    send("R1 bank1 hit", 32'hFFFF_FFFF);
    // R7: pulse lasts one cycle
    @(negedge clk);
    check("R7 accept drops after pulse", {31'd0, accept}, 32'd0);

    // R8: writes outside init ignored
    reg_write(5'd16, 8'h03);
    reg_write(5'd0, 8'h00);
    send("R8 write outside init ignored", 32'h0AA0_0000);

    // R10: addresses above 16 ignored
    init_mode = 1'b1;
    reg_write(5'd17, 8'h03); reg_write(5'd31, 8'h03);
    init_mode = 1'b0;
    send("R10 high address ignored", 32'h0AA0_0000);

    // R6 / R3: all masks open in byte mode, lowest filter wins
    init_mode = 1'b1;
    for (int i = 0; i < 8; i++) reg_write(5'(8+i), 8'hFF);
    reg_write(5'd16, 8'h02);
    init_mode = 1'b0;
    send("R6 R3 all hit lowest wins", 32'h1234_5678);
    init_mode = 1'b1;
    reg_write(5'd8, 8'h00); reg_write(5'd9, 8'h00); reg_write(5'd10, 8'h00);
    reg_write(5'd0, 8'h11); reg_write(5'd1, 8'h22); reg_write(5'd2, 8'h33);
    init_mode = 1'b0;
    send("R6 R3 first three blocked", 32'h5500_0000);
    send("R3 R5 exact byte filter 1", 32'h2200_0000);

    // R2 / R4: half mode, then closed mode
    init_mode = 1'b1;
    reg_write(5'd16, 8'h01);
    init_mode = 1'b0;
    send("R2 half mode", 32'h1122_0000);
    init_mode = 1'b1;
    reg_write(5'd16, 8'h03);
    init_mode = 1'b0;
    send("R4 closed rejects", 32'h1122_0000);

    // R1 R2 R3 R5: random configurations
    for (int r = 0; r < 300; r++) begin
      init_mode = 1'b1;
      for (int i = 0; i < 8; i++) begin
        logic [7:0] m = 8'($urandom) & 8'($urandom);
        reg_write(5'(i), 8'($urandom));
        reg_write(5'(8+i), m);
      end
      reg_write(5'd16, 8'($urandom % 4));
      init_mode = 1'b0;
      reg_write(5'($urandom % 17), 8'($urandom));
      for (int f = 0; f < 20; f++) begin
        int base = ($urandom % 2) * 4;
        int sh = $urandom % 4;
        logic [31:0] id = {sh_code[base + (sh % 2)*2], sh_code[base + (sh % 2)*2 + 1],
                           sh_code[base + 2], sh_code[base + 3]};
        if ($urandom % 3 == 0) id[31:24] = sh_code[$urandom % 8];
        id ^= ($urandom & $urandom & $urandom);
        send("R1 R2 R3 R5 random frame", id);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule